// File: doc/BRIEF.md
# Blinking Cursor Generator

This block drives the active-high cursor signal of a character-based raster display. Each character clock it compares the refresh address and scan-line number supplied by the display timing generator against a programmed cursor position and a programmed band of scan lines. When both match during active display, the cursor output goes high. The band's first and last scan lines are separate fields, so the same logic draws an underline, a block or any stripe in between.

A two-bit mode field selects one of four behaviours: a steady cursor, no cursor, or a cursor that blinks at one of two rates. The block owns a small field counter for the blinking. The counter advances once per frame-start pulse from the timing generator. A skew input delays the cursor by one character clock to cover slow display memories.

Top module: `cursor_gen`

## Requirements
- R1: With mode 00, skew low and display enable high, `cursor_o` is high in the same cycle when `refresh_addr_i` equals `cur_pos_i` and `cur_first_i <= scan_line_i <= cur_last_i`. Both line bounds are inclusive.
- R2: The comparison covers all 14 address bits, so any address from 0 to 16383 can carry the cursor. The output is low whenever the address differs in any bit.
- R3: The output is low when the scan line lies outside the band. It is also low whenever `cur_first_i` is greater than `cur_last_i`.
- R4: With mode 01, the output is never high.
- R5: A 5-bit field counter clears in reset and increments on every clock edge where `frame_start_i` is high. It wraps from 31 to 0. With mode 10, the cursor is shown only while counter bit 3 is 0.
- R6: With mode 11, the cursor is shown only while counter bit 4 is 0.
- R7: With skew low, the output is low in every cycle where `disp_en_i` is low.
- R8: With `skew_i` high, `cursor_o` equals the value that the skew-low output had in the previous cycle.
- R9: While `rst_n` is low, `cursor_o` is low. After reset the delayed value is 0 and the field counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low reset |
| frame_start_i | input | 1 | One-cycle pulse at the start of each field |
| refresh_addr_i | input | 14 | Current refresh address |
| scan_line_i | input | 5 | Scan line within the character row |
| disp_en_i | input | 1 | Display enable from the timing generator |
| cur_pos_i | input | 14 | Cursor position address |
| cur_first_i | input | 5 | First scan line of the cursor band |
| cur_last_i | input | 5 | Last scan line of the cursor band |
| cur_mode_i | input | 2 | 00 steady, 01 off, 10 blink on bit 3, 11 blink on bit 4 |
| skew_i | input | 1 | Delay the cursor by one character clock |
| cursor_o | output | 1 | Cursor output |

## Verification
The hardest states to reach are the blink phases: the slow rate only shows its hidden half after sixteen frame-start pulses. The stimulus therefore asserts the frame-start input often, so the field counter wraps several times during the run. It also forces the refresh address to equal the cursor position on a large share of cycles. This keeps address matches frequent while both counter bits move through all their combinations. Directed cycles cover the edge cases: the top address, a band of a single line, and a start line above the end line.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int ADDR_W = 14;
  localparam int LINE_W = 5;
  localparam int CNT_W  = 5;

  typedef enum logic [1:0] {
    CM_STEADY = 2'b00,
    CM_OFF    = 2'b01,
    CM_FAST   = 2'b10,
    CM_SLOW   = 2'b11
  } cur_mode_e;

  function automatic logic line_in_band(input logic [LINE_W-1:0] line,
                                        input logic [LINE_W-1:0] first,
                                        input logic [LINE_W-1:0] last);
    return (line >= first) && (line <= last);
  endfunction

  function automatic logic blink_visible(input cur_mode_e mode,
                                         input logic [CNT_W-1:0] cnt);
    logic vis;
    case (mode)
      CM_STEADY: vis = 1'b1;
      CM_OFF:    vis = 1'b0;
      CM_FAST:   vis = ~cnt[CNT_W-2];
      default:   vis = ~cnt[CNT_W-1];
    endcase
    return vis;
  endfunction
endpackage

// File: rtl/cursor_field_cnt.sv
module cursor_field_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (step_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cursor_match.sv
module cursor_match
  import cursor_pkg::*;
#(
  parameter int AW = 14,
  parameter int LW = 5
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] pos_i,
  input  logic [LW-1:0] line_i,
  input  logic [LW-1:0] first_i,
  input  logic [LW-1:0] last_i,
  output logic          hit_o
);
  always_comb hit_o = (addr_i == pos_i) && line_in_band(line_i, first_i, last_i);
endmodule

// File: rtl/cursor_skew.sv
module cursor_skew (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic skew_i,
  output logic out_o
);
  logic held_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= raw_i;
  end
  always_comb out_o = rst_n & (skew_i ? held_q : raw_i);
endmodule

// File: rtl/cursor_gen.sv
module cursor_gen
  import cursor_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LINE_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start_i,
  input  logic [AW-1:0] refresh_addr_i,
  input  logic [LW-1:0] scan_line_i,
  input  logic          disp_en_i,
  input  logic [AW-1:0] cur_pos_i,
  input  logic [LW-1:0] cur_first_i,
  input  logic [LW-1:0] cur_last_i,
  input  logic [1:0]    cur_mode_i,
  input  logic          skew_i,
  output logic          cursor_o
);
  logic [CW-1:0] field_cnt;
  logic          hit_w;
  logic          visible_w;
  logic          raw_w;

  cursor_field_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step_i(frame_start_i), .cnt_o(field_cnt)
  );

  cursor_match #(.AW(AW), .LW(LW)) u_match (
    .addr_i(refresh_addr_i), .pos_i(cur_pos_i), .line_i(scan_line_i),
    .first_i(cur_first_i), .last_i(cur_last_i), .hit_o(hit_w)
  );

  always_comb visible_w = blink_visible(cur_mode_e'(cur_mode_i), field_cnt);
  always_comb raw_w     = hit_w & visible_w & disp_en_i;

  cursor_skew u_skew (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_w), .skew_i(skew_i), .out_o(cursor_o)
  );
endmodule

// File: rtl/cursor_gen_chk.sv
module cursor_gen_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start_i,
  input logic          disp_en_i,
  input logic [1:0]    cur_mode_i,
  input logic          skew_i,
  input logic [4:0]    cur_first_i,
  input logic [4:0]    cur_last_i,
  input logic [CW-1:0] field_cnt,
  input logic          raw_w,
  input logic          cursor_o
);
  assert_mode_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode_i == 2'b01 && !skew_i) |-> !cursor_o);
  assert_band_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_first_i > cur_last_i && !skew_i) |-> !cursor_o);
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> field_cnt == $past(field_cnt) + 1'b1);
  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> $stable(field_cnt));
  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_en_i && !skew_i) |-> !cursor_o);
  assert_skew_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!skew_i || cursor_o == $past(raw_w)));
  always_comb begin
    if (!rst_n) assert_reset_low_R9: assert (!cursor_o);
  end
endmodule

bind cursor_gen cursor_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i), .disp_en_i(disp_en_i),
  .cur_mode_i(cur_mode_i), .skew_i(skew_i), .cur_first_i(cur_first_i),
  .cur_last_i(cur_last_i), .field_cnt(field_cnt), .raw_w(raw_w), .cursor_o(cursor_o)
);

// File: tb/cursor_gen_tb.sv
module cursor_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start_i = 1'b0;
  logic [13:0] refresh_addr_i = '0;
  logic [4:0]  scan_line_i = '0;
  logic        disp_en_i = 1'b0;
  logic [13:0] cur_pos_i = '0;
  logic [4:0]  cur_first_i = '0;
  logic [4:0]  cur_last_i = '0;
  logic [1:0]  cur_mode_i = '0;
  logic        skew_i = 1'b0;
  logic        cursor_o;

  int checks = 0;
  int fails  = 0;
  logic [4:0] m_cnt = '0;
  logic       m_prev = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cursor_gen u_dut (.*);

  function automatic logic exp_plain(logic [13:0] a, logic [13:0] p, logic [4:0] l,
                                     logic [4:0] f, logic [4:0] e, logic de,
                                     logic [1:0] m, logic [4:0] c);
    logic show;
    if (m == 2'b01) show = 0;
    else if (m == 2'b10) show = (c[3] == 1'b0);
    else if (m == 2'b11) show = (c[4] == 1'b0);
    else show = 1;
    return show && de && (a == p) && (f <= l) && (l <= e);
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: cursor_o=%b expected %b (addr=%0d pos=%0d line=%0d band=%0d..%0d mode=%0d skew=%b de=%b cnt=%0d)",
               req, got, exp, refresh_addr_i, cur_pos_i, scan_line_i, cur_first_i,
               cur_last_i, cur_mode_i, skew_i, disp_en_i, m_cnt);
    end
  endtask

  task automatic step(input string req);
    logic e;
    #1;
    e = exp_plain(refresh_addr_i, cur_pos_i, scan_line_i, cur_first_i, cur_last_i,
                  disp_en_i, cur_mode_i, m_cnt);
    check(cursor_o, skew_i ? m_prev : e, req);
    m_prev = e;
    if (frame_start_i) m_cnt = m_cnt + 1'b1;
    @(negedge clk);
  endtask

  task automatic drive(logic [13:0] a, logic [13:0] p, logic [4:0] l, logic [4:0] f,
                       logic [4:0] e, logic de, logic [1:0] m, logic sk, logic fs);
    refresh_addr_i = a; cur_pos_i = p; scan_line_i = l; cur_first_i = f;
    cur_last_i = e; disp_en_i = de; cur_mode_i = m; skew_i = sk; frame_start_i = fs;
  endtask

  initial begin
    void'($urandom(32'd1234));
    drive(14'd5, 14'd5, 5'd2, 5'd0, 5'd7, 1, 2'b00, 0, 1);
    repeat (3) @(negedge clk);
    #1 check(cursor_o, 1'b0, "R9 reset low");
    @(negedge clk);
    rst_n = 1'b1;
    frame_start_i = 0;
    // R1 steady hit, R9 counter cleared (mode 10 visible at count 0)
    step("R1 steady hit");
    drive(14'd5, 14'd5, 5'd2, 5'd0, 5'd7, 1, 2'b10, 0, 0); step("R9 counter zero after reset");
    // R2 top address and single differing bit
    drive(14'h3FFF, 14'h3FFF, 5'd4, 5'd4, 5'd4, 1, 2'b00, 0, 0); step("R2 top address hit");
    drive(14'h1FFF, 14'h3FFF, 5'd4, 5'd4, 5'd4, 1, 2'b00, 0, 0); step("R2 high bit differs");
    // R3 band edges and inverted band
    drive(14'd9, 14'd9, 5'd3, 5'd4, 5'd6, 1, 2'b00, 0, 0); step("R3 below band");
    drive(14'd9, 14'd9, 5'd7, 5'd4, 5'd6, 1, 2'b00, 0, 0); step("R3 above band");
    drive(14'd9, 14'd9, 5'd6, 5'd4, 5'd6, 1, 2'b00, 0, 0); step("R1 last line inclusive");
    drive(14'd9, 14'd9, 5'd5, 5'd6, 5'd4, 1, 2'b00, 0, 0); step("R3 first above last");
    // R4 off, R7 blank
    drive(14'd9, 14'd9, 5'd5, 5'd0, 5'd31, 1, 2'b01, 0, 0); step("R4 off mode");
    drive(14'd9, 14'd9, 5'd5, 5'd0, 5'd31, 0, 2'b00, 0, 0); step("R7 display disabled");
    // R8 skew: hit then miss
    drive(14'd9, 14'd9, 5'd5, 5'd0, 5'd31, 1, 2'b00, 1, 0); step("R8 skew delayed");
    drive(14'd8, 14'd9, 5'd5, 5'd0, 5'd31, 1, 2'b00, 1, 0); step("R8 skew trailing");
    drive(14'd8, 14'd9, 5'd5, 5'd0, 5'd31, 1, 2'b00, 1, 0); step("R8 skew off");
    // R5/R6 walk the counter through two wraps
    for (int i = 0; i < 70; i++) begin
      drive(14'd7, 14'd7, 5'd1, 5'd0, 5'd3, 1, (i % 2) ? 2'b11 : 2'b10, 0, 1);
      step((i % 2) ? "R6 slow blink" : "R5 fast blink");
    end
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [13:0] p;
      logic [1:0] m;
      string tag;
      p = 14'($urandom);
      m = 2'($urandom);
      drive(($urandom % 3 != 0) ? p : 14'($urandom), p, 5'($urandom % 12),
            5'($urandom % 10), 5'($urandom % 12), ($urandom % 8) != 0, m,
            ($urandom % 4) == 0, ($urandom % 5) == 0);
      if (skew_i) tag = "R8 random skew";
      else if (!disp_en_i) tag = "R7 random blank";
      else if (m == 2'b01) tag = "R4 random off";
      else if (m == 2'b10) tag = "R5 random fast";
      else if (m == 2'b11) tag = "R6 random slow";
      else tag = "R1 random steady";
      step(tag);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not end, expected completion");
      end
    join_any
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule